// File: doc/BRIEF.md
# Cache-Line Request Merger

This block takes a set of N pending memory requests. Each request holds a 128-bit line-data word and a 16-bit byte-enable mask. From these it builds one combined write request for a single cache line. Requests are grouped by an N-by-N match matrix that is computed upstream. Bit j of row i is set when requests i and j sit on the same line, meaning their address bits 4 and up are equal. The diagonal bit of a row marks that request as active.

The block picks the lowest-numbered active request as the leader. It then ORs together the data and byte enables of every request named in the leader's matrix row. The upstream logic guarantees that merged requests never have overlapping byte enables, so the OR loses nothing. The result is registered together with a valid flag, the leader index and a mask of the rows consumed. Upstream logic uses that mask to retire the merged requests and present the rest on a later cycle.

Top module: `line_merger`

## Requirements
- R1: While reset is asserted and directly after it, vld_o is 0 and data_o, ben_o, used_o and idx_o are all zero.
- R2: The leader idx_o is the lowest index i whose diagonal bit match_i[i*N+i] is set.
- R3: data_o is the bitwise OR of the data_i words (row j at bits j*DW +: DW) of every row j for which bit j of the leader's match row (match_i[idx*N +: N]) is set.
- R4: ben_o is the bitwise OR of the ben_i masks (row j at bits j*BW +: BW) of the same set of rows as in R3.
- R5: used_o equals the leader's match row, so bit j set means row j was merged.
- R6: When no diagonal bit is set, vld_o is 0 and data_o, ben_o, used_o and idx_o are zero on the following cycle.
- R7: All outputs are registered. A change on the inputs shows at the outputs only after the next rising clock edge.
- R8: Matrix rows of inactive requests have no effect, including their off-diagonal bits. An active row that is not in the leader's match row contributes nothing to the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| match_i | input | N*N | Match matrix; row i at bits i*N +: N, bit j of row i set when rows i and j share a line |
| data_i | input | N*DW | Line data of each request, row j at bits j*DW +: DW |
| ben_i | input | N*BW | Byte enables of each request, row j at bits j*BW +: BW |
| vld_o | output | 1 | Merged record valid |
| idx_o | output | IW | Index of the chosen leader row |
| data_o | output | DW | Merged line data |
| ben_o | output | BW | Merged byte enables |
| used_o | output | N | Rows folded into this merged record |

## Verification
The hardest case to reach is a matrix whose inactive rows still carry stray off-diagonal bits while a higher active row leads. A correct design has to ignore those bits, and a design that picks the wrong row or reads the wrong row slice would pick them up. The stimulus builds that case directly. It leaves row 0 inactive but marks it as matching rows 1 and 3, and it makes row 3 active but not linked to leader row 1. The expected output then differs sharply from what a wrong choice of row would give.

// File: rtl/line_merger.sv
`timescale 1ns/1ps
module line_merger #(
  parameter int N  = 4,
  parameter int DW = 128,
  parameter int BW = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N*N-1:0]  match_i,
  input  logic [N*DW-1:0] data_i,
  input  logic [N*BW-1:0] ben_i,
  output logic            vld_o,
  output logic [IW-1:0]   idx_o,
  output logic [DW-1:0]   data_o,
  output logic [BW-1:0]   ben_o,
  output logic [N-1:0]    used_o
);

  logic [N-1:0]  diag;
  logic [IW-1:0] pick;
  logic [N-1:0]  row;
  logic [DW-1:0] dacc;
  logic [BW-1:0] bacc;
  wire           any = |diag;

  for (genvar g = 0; g < N; g++) begin : g_diag
    assign diag[g] = match_i[g*N+g];
  end

  always_comb begin
    pick = '0;
    for (int i = N-1; i >= 0; i--)
      if (diag[i]) pick = IW'(i);
  end

  assign row = any ? match_i[pick*N +: N] : '0;

  always_comb begin
    dacc = '0;
    bacc = '0;
    for (int j = 0; j < N; j++)
      if (row[j]) begin
        dacc |= data_i[j*DW +: DW];
        bacc |= ben_i[j*BW +: BW];
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      vld_o  <= 1'b0;
      idx_o  <= '0;
      data_o <= '0;
      ben_o  <= '0;
      used_o <= '0;
    end else begin
      vld_o  <= any;
      idx_o  <= pick;
      data_o <= dacc;
      ben_o  <= bacc;
      used_o <= row;
    end

  a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_o |-> (data_o == '0 && ben_o == '0 && used_o == '0 && idx_o == '0));

  a_r5_used_holds_leader: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> used_o[idx_o]);

  a_r2_lowest_leader: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> ((match_diag_past & ((N'(1) << idx_o) - N'(1))) == '0));

  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (|diag) |=> vld_o);

  a_r7_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !(|diag) |=> !vld_o);

  logic [N-1:0] match_diag_past;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) match_diag_past <= '0;
    else        match_diag_past <= diag;

endmodule

// File: tb/sim_line_merger.sv
`timescale 1ns/1ps
module sim_line_merger;
  localparam int N = 4, DW = 128, BW = 16, IW = 2;

  logic clk = 0, rst_n = 0;
  logic [N*N-1:0]  match_i = '0;
  logic [N*DW-1:0] data_i = '0;
  logic [N*BW-1:0] ben_i = '0;
  logic vld_o;
  logic [IW-1:0] idx_o;
  logic [DW-1:0] data_o;
  logic [BW-1:0] ben_o;
  logic [N-1:0] used_o;

  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  line_merger #(.N(N), .DW(DW), .BW(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .match_i(match_i), .data_i(data_i), .ben_i(ben_i),
    .vld_o(vld_o), .idx_o(idx_o), .data_o(data_o), .ben_o(ben_o), .used_o(used_o));

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic setreq(int r, logic [N-1:0] mrow, logic [BW-1:0] ben);
    logic [DW-1:0] d;
    d = '0;
    for (int b = 0; b < BW; b++)
      if (ben[b]) d[b*8 +: 8] = 8'(8'h10 * (r + 1) + b);
    match_i[r*N +: N] = mrow;
    ben_i[r*BW +: BW] = ben;
    data_i[r*DW +: DW] = d;
  endtask

  function automatic logic [DW-1:0] rdat(int r);
    return data_i[r*DW +: DW];
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_out(string tag, logic v, int idx, logic [N-1:0] used,
                            logic [DW-1:0] d, logic [BW-1:0] b);
    chk({tag, " vld"}, DW'(vld_o), DW'(v));
    chk({tag, " idx"}, DW'(idx_o), DW'(idx));
    chk({tag, " used"}, DW'(used_o), DW'(used));
    chk({tag, " data"}, data_o, d);
    chk({tag, " ben"}, DW'(ben_o), DW'(b));
  endtask

  task automatic clear();
    match_i = '0; data_i = '0; ben_i = '0;
  endtask

  task automatic t_reset();
    expect_out("R1 reset", 0, 0, '0, '0, '0);
    @(negedge clk); rst_n = 1;
    chk("R1 after release", DW'(vld_o), '0);
  endtask

  task automatic t_single();
    clear();
    setreq(2, 4'b0100, 16'h00F0);
    step();
    expect_out("R2 R3 R4 R5 single", 1, 2, 4'b0100, rdat(2), 16'h00F0);
  endtask

  task automatic t_pair();
    clear();
    setreq(0, 4'b0101, 16'h000F);
    setreq(1, 4'b0010, 16'h000F);
    setreq(2, 4'b0101, 16'hF000);
    step();
    expect_out("R3 R4 R5 R8 pair", 1, 0, 4'b0101, rdat(0) | rdat(2), 16'hF00F);
  endtask

  task automatic t_all();
    clear();
    setreq(0, 4'b1111, 16'h0003);
    setreq(1, 4'b1111, 16'h0030);
    setreq(2, 4'b1111, 16'h0300);
    setreq(3, 4'b1111, 16'h3000);
    step();
    expect_out("R3 R4 all", 1, 0, 4'b1111,
               rdat(0) | rdat(1) | rdat(2) | rdat(3), 16'h3333);
  endtask

  task automatic t_stray();
    clear();
    setreq(0, 4'b1010, 16'hFFFF);
    setreq(1, 4'b0110, 16'h00FF);
    setreq(2, 4'b0110, 16'hFF00);
    setreq(3, 4'b1000, 16'h0F0F);
    step();
    expect_out("R2 R8 stray", 1, 1, 4'b0110, rdat(1) | rdat(2), 16'hFFFF);
  endtask

  task automatic t_idle();
    clear();
    setreq(0, 4'b1110, 16'hFFFF);
    step();
    expect_out("R6 idle", 0, 0, '0, '0, '0);
  endtask

  task automatic t_latency();
    clear();
    setreq(3, 4'b1000, 16'h8001);
    step();
    clear();
    setreq(1, 4'b0010, 16'h0100);
    #1;
    chk("R7 hold idx", DW'(idx_o), DW'(3));
    chk("R7 hold ben", DW'(ben_o), DW'(16'h8001));
    step();
    chk("R7 update idx", DW'(idx_o), DW'(1));
    chk("R7 update ben", DW'(ben_o), DW'(16'h0100));
  endtask

  initial begin
    #(200000 * 4);
    tests++; fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    t_single();
    t_pair();
    t_all();
    t_stray();
    t_idle();
    t_latency();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule